// File: doc/BRIEF.md
# TDM Codec Link Frame Engine

This block runs the serial side of a time-division audio codec link. From the system clock it derives a bit clock. It counts that clock into frames of 16 slots, each 16 bits wide, so one frame lasts 256 bit-clock periods. It places a one-period, active-high frame sync in the last period of each frame, one bit clock ahead of the first bit of slot 0.

A controller provides a flat bank of transmit words, one 16-bit word per slot. The engine shifts them out most significant bit first and changes the line on the rising bit-clock edge. The bank is captured as the frame begins, so a rewrite partway through a frame only shows in the next frame. Received bits are sampled on the falling edge and gathered into a parallel receive bank.

Two compile-time masks choose which slots carry traffic. Transmit slots that are not enabled keep the line low. Bits that arrive in receive slots that are not enabled are dropped. After the last enabled receive slot has been stored, a one-cycle `frame_done_o` pulse tells the controller that it may read the new words and prepare the next transmit words.

Top module: `tdm_link_engine`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `sclk_o`, `fsync_o`, `sdata_o` and `frame_done_o` are low and every bit of `rx_bank_o` is zero.
- R2: `sclk_o` is a square wave, 2*HALF_PER system clocks per period (4 at the default), with equal high and low times.
- R3: A frame is SLOT_W*NUM_SLOTS = 256 bit periods. Number the bit periods 0 to 255, each starting at a rising edge of `sclk_o`. `fsync_o` is high for exactly period 255 and low in all others, and it changes only together with a rising edge of `sclk_o`. The first bit period after reset is period 255.
- R4: In bit period p, an enabled slot k = p/16 drives `sdata_o` with bit 15-(p mod 16) of its word. The word is taken from `tx_bank_i[16k+15:16k]`, so it goes out most significant bit first. `sdata_o` changes only with a rising edge of `sclk_o`.
- R5: Bit k of TX_MASK enables transmit slot k. The default is 0x007F, which enables slots 0 to 6. In a slot that is not enabled, `sdata_o` is low whatever the bank holds.
- R6: The transmit words for a frame are the value of `tx_bank_i` at the rising `sclk_o` edge that starts period 0. A change later in that frame does not affect that frame's bits and is used in the next frame.
- R7: `sdata_i` is sampled on each falling edge of `sclk_o`, most significant bit first. The 16 bits of an enabled receive slot k are written as one word to `rx_bank_o[16k+15:16k]` on the falling edge within that slot's last bit period. Bit k of RX_MASK enables receive slot k, and the default is 0x001F, which enables slots 0 to 4.
- R8: Bits that arrive in a receive slot that is not enabled are discarded, and that slot's field in `rx_bank_o` stays zero.
- R9: `frame_done_o` is high for exactly one system clock per frame. The pulse sits in the last bit period of the highest enabled receive slot (period 79 at the default masks), on the cycle after the falling `sclk_o` edge. On that cycle `rx_bank_o` already holds the words just received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_bank_i | input | SLOT_W*NUM_SLOTS | Transmit words, slot k in bits [16k+15:16k] |
| rx_bank_o | output | SLOT_W*NUM_SLOTS | Received words, slot k in bits [16k+15:16k] |
| sclk_o | output | 1 | Generated bit clock |
| fsync_o | output | 1 | Early frame sync, active high |
| sdata_o | output | 1 | Serial transmit data |
| sdata_i | input | 1 | Serial receive data |
| frame_done_o | output | 1 | One-cycle pulse after the last enabled receive slot is stored |

## Verification
A wrong slot or bit counter moves `fsync_o` away from period 255, or shifts the serial data by whole bits. The bench compares every bit period, so this shows within one bit period of the fault. A stale or torn transmit shadow shows as wrong bits in the first frame after the bank changes. A bad receive shift register or write enable shows as a wrong word, or a nonzero disabled field, when `frame_done_o` fires. That is at most one frame later, and a `frame_done_o` pulse that is missing or misplaced is caught in the same frame.

// File: rtl/tdm_link_pkg.sv
package tdm_link_pkg;

  // strobes raised on the system clock cycle whose edge moves the bit clock
  typedef struct packed {
    logic rise;
    logic fall;
  } sclk_evt_t;

  // index of the highest set bit in the low n bits, -1 when none are set
  function automatic int top_set_bit(input logic [63:0] m, input int n);
    int r;
    r = -1;
    for (int i = 0; i < n; i++) begin
      if (m[i]) r = i;
    end
    return r;
  endfunction

endpackage

// File: rtl/tdm_bit_timer.sv
module tdm_bit_timer
  import tdm_link_pkg::*;
#(
  parameter int HALF_PER = 2
) (
  input  logic      clk,
  input  logic      rst,
  output logic      sclk_q,
  output sclk_evt_t evt
);

  localparam int HW = (HALF_PER > 1) ? $clog2(HALF_PER) : 1;

  logic [HW-1:0] hcnt_q;
  logic          tick;

  assign tick = (hcnt_q == HW'(HALF_PER - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt_q <= '0;
      sclk_q <= 1'b0;
    end else if (tick) begin
      hcnt_q <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      hcnt_q <= hcnt_q + 1'b1;
    end
  end

  assign evt.rise = tick & ~sclk_q;
  assign evt.fall = tick &  sclk_q;

endmodule

// File: rtl/tdm_frame_counter.sv
module tdm_frame_counter #(
  parameter int SLOT_W    = 16,
  parameter int NUM_SLOTS = 16,
  localparam int SW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int BW = (SLOT_W > 1) ? $clog2(SLOT_W) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [SW-1:0] slot_q,
  output logic [BW-1:0] bit_q,
  output logic [SW-1:0] slot_n,
  output logic [BW-1:0] bit_n,
  output logic          fsync_q
);

  localparam logic [SW-1:0] LAST_SLOT = SW'(NUM_SLOTS - 1);
  localparam logic [BW-1:0] LAST_BIT  = BW'(SLOT_W - 1);

  always_comb begin
    if (bit_q == LAST_BIT) begin
      bit_n  = '0;
      slot_n = (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
    end else begin
      bit_n  = bit_q + 1'b1;
      slot_n = slot_q;
    end
  end

  // reset parks the counter two periods before slot 0, so the first
  // period after reset is the sync period
  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q  <= LAST_SLOT;
      bit_q   <= BW'(SLOT_W - 2);
      fsync_q <= 1'b0;
    end else if (adv) begin
      slot_q  <= slot_n;
      bit_q   <= bit_n;
      fsync_q <= (slot_n == LAST_SLOT) && (bit_n == LAST_BIT);
    end
  end

endmodule

// File: rtl/tdm_tx_serializer.sv
module tdm_tx_serializer #(
  parameter int SLOT_W    = 16,
  parameter int NUM_SLOTS = 16,
  parameter logic [NUM_SLOTS-1:0] TX_MASK = 'h7F,
  localparam int SW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int BW = (SLOT_W > 1) ? $clog2(SLOT_W) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        adv,
  input  logic [SW-1:0]               slot_n,
  input  logic [BW-1:0]               bit_n,
  input  logic [SLOT_W*NUM_SLOTS-1:0] bank_i,
  output logic                        sdata_q
);

  logic [SLOT_W-1:0] shadow [NUM_SLOTS];
  logic              start;
  logic [SLOT_W-1:0] fresh_word;
  logic [SLOT_W-1:0] held_word;
  logic [SLOT_W-1:0] pick_word;
  logic              next_bit;

  assign start = adv && (slot_n == '0) && (bit_n == '0);

  // only enabled slots get storage; idle slots read as zero
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    if (TX_MASK[g]) begin : g_on
      logic [SLOT_W-1:0] hold_q;
      always_ff @(posedge clk) begin
        if (rst)        hold_q <= '0;
        else if (start) hold_q <= bank_i[g*SLOT_W +: SLOT_W];
      end
      assign shadow[g] = hold_q;
    end else begin : g_off
      assign shadow[g] = '0;
    end
  end

  // slot 0 is fetched straight from the bank on the latch edge itself
  assign fresh_word = bank_i[int'(slot_n)*SLOT_W +: SLOT_W];
  assign held_word  = shadow[slot_n];
  assign pick_word  = start ? fresh_word : held_word;
  assign next_bit   = pick_word[BW'(SLOT_W - 1) - bit_n] & TX_MASK[slot_n];

  always_ff @(posedge clk) begin
    if (rst)      sdata_q <= 1'b0;
    else if (adv) sdata_q <= next_bit;
  end

endmodule

// File: rtl/tdm_rx_deserializer.sv
module tdm_rx_deserializer
  import tdm_link_pkg::*;
#(
  parameter int SLOT_W    = 16,
  parameter int NUM_SLOTS = 16,
  parameter logic [NUM_SLOTS-1:0] RX_MASK = 'h1F,
  localparam int SW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int BW = (SLOT_W > 1) ? $clog2(SLOT_W) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        smp,
  input  logic [SW-1:0]               slot_q,
  input  logic [BW-1:0]               bit_q,
  input  logic                        sdata_i,
  output logic [SLOT_W*NUM_SLOTS-1:0] bank_o,
  output logic                        done_q
);

  localparam int LAST_RX  = top_set_bit(64'(RX_MASK), NUM_SLOTS);
  localparam bit HAS_RX   = (LAST_RX >= 0);
  localparam int LAST_IDX = HAS_RX ? LAST_RX : 0;

  logic [SLOT_W-1:0] sh_q;
  logic [SLOT_W-1:0] sh_n;
  logic              word_end;

  assign sh_n     = {sh_q[SLOT_W-2:0], sdata_i};
  assign word_end = smp && (bit_q == BW'(SLOT_W - 1));

  always_ff @(posedge clk) begin
    if (rst)      sh_q <= '0;
    else if (smp) sh_q <= sh_n;
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    if (RX_MASK[g]) begin : g_on
      logic [SLOT_W-1:0] word_q;
      always_ff @(posedge clk) begin
        if (rst)                                 word_q <= '0;
        else if (word_end && slot_q == SW'(g))   word_q <= sh_n;
      end
      assign bank_o[g*SLOT_W +: SLOT_W] = word_q;
    end else begin : g_off
      assign bank_o[g*SLOT_W +: SLOT_W] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) done_q <= 1'b0;
    else     done_q <= HAS_RX && word_end && (slot_q == SW'(LAST_IDX));
  end

endmodule

// File: rtl/tdm_link_engine.sv
module tdm_link_engine
  import tdm_link_pkg::*;
#(
  parameter int SLOT_W    = 16,
  parameter int NUM_SLOTS = 16,
  parameter int HALF_PER  = 2,
  parameter logic [NUM_SLOTS-1:0] TX_MASK = 'h7F,
  parameter logic [NUM_SLOTS-1:0] RX_MASK = 'h1F
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [SLOT_W*NUM_SLOTS-1:0] tx_bank_i,
  output logic [SLOT_W*NUM_SLOTS-1:0] rx_bank_o,
  output logic                        sclk_o,
  output logic                        fsync_o,
  output logic                        sdata_o,
  input  logic                        sdata_i,
  output logic                        frame_done_o
);

  localparam int SW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam int BW = (SLOT_W > 1) ? $clog2(SLOT_W) : 1;

  sclk_evt_t     evt;
  logic [SW-1:0] slot_q, slot_n;
  logic [BW-1:0] bit_q, bit_n;

  tdm_bit_timer #(.HALF_PER(HALF_PER)) timer_i (
    .clk    (clk),
    .rst    (rst),
    .sclk_q (sclk_o),
    .evt    (evt)
  );

  tdm_frame_counter #(.SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS)) frame_i (
    .clk     (clk),
    .rst     (rst),
    .adv     (evt.rise),
    .slot_q  (slot_q),
    .bit_q   (bit_q),
    .slot_n  (slot_n),
    .bit_n   (bit_n),
    .fsync_q (fsync_o)
  );

  tdm_tx_serializer #(.SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS), .TX_MASK(TX_MASK)) tx_i (
    .clk     (clk),
    .rst     (rst),
    .adv     (evt.rise),
    .slot_n  (slot_n),
    .bit_n   (bit_n),
    .bank_i  (tx_bank_i),
    .sdata_q (sdata_o)
  );

  tdm_rx_deserializer #(.SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS), .RX_MASK(RX_MASK)) rx_i (
    .clk     (clk),
    .rst     (rst),
    .smp     (evt.fall),
    .slot_q  (slot_q),
    .bit_q   (bit_q),
    .sdata_i (sdata_i),
    .bank_o  (rx_bank_o),
    .done_q  (frame_done_o)
  );

endmodule

// File: rtl/tdm_link_engine_chk.sv
module tdm_link_engine_chk #(
  parameter int SLOT_W    = 16,
  parameter int NUM_SLOTS = 16,
  parameter logic [NUM_SLOTS-1:0] TX_MASK = 'h7F,
  localparam int SW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        sclk_o,
  input logic                        fsync_o,
  input logic                        sdata_o,
  input logic                        frame_done_o,
  input logic [SLOT_W*NUM_SLOTS-1:0] rx_bank_o,
  input logic [SW-1:0]               cur_slot
);

  p_fsync_edge_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(fsync_o) |-> $rose(sclk_o));

  p_sdata_edge_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdata_o) |-> $rose(sclk_o));

  p_idle_low_r5: assert property (@(posedge clk) disable iff (rst)
    !TX_MASK[cur_slot] |-> !sdata_o);

  p_rx_fall_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_bank_o) |-> $fell(sclk_o));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    frame_done_o |=> !frame_done_o);

  p_done_fall_r9: assert property (@(posedge clk) disable iff (rst)
    frame_done_o |-> $fell(sclk_o));

endmodule

bind tdm_link_engine tdm_link_engine_chk #(
  .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS), .TX_MASK(TX_MASK)
) chk_i (
  .clk          (clk),
  .rst          (rst),
  .sclk_o       (sclk_o),
  .fsync_o      (fsync_o),
  .sdata_o      (sdata_o),
  .frame_done_o (frame_done_o),
  .rx_bank_o    (rx_bank_o),
  .cur_slot     (slot_q)
);

// File: tb/tdm_link_engine_tb_top.sv
`timescale 1ns/1ps
module tdm_link_engine_tb_top;

  localparam int W  = 16;
  localparam int NS = 16;
  localparam int H  = 2;
  localparam int NB = W * NS;
  localparam logic [NS-1:0] TXM = 16'h007F;
  localparam logic [NS-1:0] RXM = 16'h001F;
  localparam int LAST_RX = 4;
  localparam int FRAMES  = 24;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NB-1:0] tx_bank = '0;
  logic [NB-1:0] rx_bank;
  logic          sclk, fsync, sdata_o, frame_done;
  logic          sdata_i = 1'b0;

  int  vec = 0;
  int  bad = 0;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;

  tdm_link_engine #(
    .SLOT_W(W), .NUM_SLOTS(NS), .HALF_PER(H), .TX_MASK(TXM), .RX_MASK(RXM)
  ) dut_i (
    .clk          (clk),
    .rst          (rst),
    .tx_bank_i    (tx_bank),
    .rx_bank_o    (rx_bank),
    .sclk_o       (sclk),
    .fsync_o      (fsync),
    .sdata_o      (sdata_o),
    .sdata_i      (sdata_i),
    .frame_done_o (frame_done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pattern_word(input int fr, input int s);
    case (fr)
      1:       return '1;
      2:       return '0;
      3:       return (s % 2 == 0) ? 16'hA5C3 : 16'h5A3C;
      default: return W'($urandom);
    endcase
  endfunction

  function automatic logic expected_tx_bit(input logic [W-1:0] w, input int s, input int b);
    return TXM[s] ? w[b] : 1'b0;
  endfunction

  initial begin
    logic [W-1:0] exp_tx [NS];
    logic [W-1:0] rx_cur [NS];
    int  pos, fr, since, chg_pos;
    bit  prev_sclk, first_rise, changed, saw_done;
    void'($urandom(32'd1357));
    for (int s = 0; s < NS; s++) begin
      exp_tx[s] = '0;
      rx_cur[s] = W'($urandom);
      tx_bank[s*W +: W] = W'($urandom);
    end
    repeat (4) @(negedge clk);
    // R1: outputs quiet while reset is held
    check("R1 sclk", 32'(sclk), 0);
    check("R1 fsync", 32'(fsync), 0);
    check("R1 sdata", 32'(sdata_o), 0);
    check("R1 done", 32'(frame_done), 0);
    check("R1 rx bank", 32'(|rx_bank), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 sclk after release", 32'(sclk), 0);
    check("R1 rx bank after release", 32'(|rx_bank), 0);
    pos = NB - 2; fr = 0; since = 1; chg_pos = NB / 2;
    prev_sclk = sclk; first_rise = 1'b1; changed = 1'b0; saw_done = 1'b0;

    while (fr <= FRAMES) begin
      @(negedge clk);
      since++;
      if (sclk && !prev_sclk) begin
        if (!first_rise) check("R2 bit period", 32'(since), 32'(2 * H));
        first_rise = 1'b0;
        since = 0;
        pos = (pos + 1) % NB;
        if (pos == 0) begin
          if (fr >= 1) check("R9 one done per frame", 32'(saw_done), 1);
          saw_done = 1'b0;
          fr++;
          changed = 1'b0;
          chg_pos = 1 + int'($urandom % (NB - 3));
          for (int s = 0; s < NS; s++) begin
            exp_tx[s] = tx_bank[s*W +: W];
            rx_cur[s] = pattern_word(fr, s + 7);
          end
        end
        check("R3 fsync", 32'(fsync), 32'(pos == NB - 1));
        begin
          int s, b;
          s = pos / W;
          b = W - 1 - (pos % W);
          if (!TXM[s])
            check("R5 idle slot", 32'(sdata_o), 0);
          else if (changed)
            check("R6 held bank", 32'(sdata_o), 32'(expected_tx_bit(exp_tx[s], s, b)));
          else
            check("R4 tx bit", 32'(sdata_o), 32'(expected_tx_bit(exp_tx[s], s, b)));
          sdata_i = rx_cur[s][b];
        end
        if (pos == chg_pos) begin
          for (int s = 0; s < NS; s++) tx_bank[s*W +: W] = pattern_word(fr + 1, s);
          changed = 1'b1;
        end
      end
      if (frame_done) begin
        saw_done = 1'b1;
        check("R9 done position", 32'(pos), 32'(LAST_RX * W + W - 1));
        for (int s = 0; s < NS; s++) begin
          if (RXM[s]) check("R7 rx word", 32'(rx_bank[s*W +: W]), 32'(rx_cur[s]));
          else        check("R8 discarded slot", 32'(rx_bank[s*W +: W]), 0);
        end
      end
      prev_sclk = sclk;
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

endmodule